// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is the arithmetic datapath a small processor core uses for multiply and multiply-accumulate instructions. Each cycle it can accept two 16-bit operands, an operation code and mode bits. It multiplies the operands in a three-stage pipeline and then loads the product into a single 32-bit accumulator, adds it to the accumulator, or subtracts it from the accumulator.

Operands can be unsigned integers, signed integers or signed Q15 fractions. In fractional mode the product is doubled, so the accumulator holds a Q31 value. An optional saturation mode clamps results that leave the accumulator's range. A sticky overflow flag records every out-of-range result, whether or not it was clamped.

The accumulate happens in the last stage and reads the accumulator register directly. Operations issued on consecutive cycles therefore chain without a stall. A direct load of the accumulator wins over an operation that completes on the same edge.

Top module: `mac_unit`

## Requirements
- R1: After reset, `acc_o` is 0, `ovf_o` is 0, `zero_o` is 1 and `neg_o` is 0.
- R2: The edge that samples `valid_i` high is the first of three rising edges. The result of that operation appears on `acc_o` after the third edge. `acc_o` does not change after the first or the second edge.
- R3: With `signed_i`=0 and `frac_i`=0, both operands are unsigned 16-bit integers. The accumulator is then treated as unsigned, with range 0 to 0xFFFFFFFF.
- R4: With `signed_i`=1 and `frac_i`=0, both operands are two's-complement 16-bit integers. The accumulator is then treated as signed.
- R5: With `frac_i`=1 (whatever `signed_i` is), both operands are signed Q15 values. The product is their signed product shifted left by one bit. The accumulator is then treated as signed Q31.
- R6: `op_i` selects the operation: 2'b00 loads the product into the accumulator, 2'b01 adds the product to it, 2'b10 subtracts the product from it. 2'b11 leaves both the accumulator and the overflow flag unchanged.
- R7: Operations can be issued on every cycle with no stall. Each one uses the accumulator value left by the operation issued one cycle earlier.
- R8: With `sat_i`=1, a result outside the accumulator's range is clamped. In signed and fractional modes the limits are 0x7FFFFFFF and 0x80000000. In unsigned mode they are 0xFFFFFFFF and 0x00000000.
- R9: With `sat_i`=0, a result outside the range is wrapped modulo 2^32 and still sets `ovf_o`.
- R10: `ovf_o` is sticky. Once set, it stays high until the accumulator is written through `acc_wr_i`.
- R11: `acc_wr_i` loads `acc_wdata_i` into the accumulator and clears `ovf_o`, visible after one edge. The load takes priority over an operation that completes on the same edge, and that operation is discarded.
- R12: `zero_o` is high exactly when the accumulator is 0. `neg_o` equals accumulator bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for the operands and opcode |
| op_i | input | 2 | 00 load, 01 add, 10 subtract, 11 no effect |
| signed_i | input | 1 | Signed integer operands |
| frac_i | input | 1 | Signed Q15 fractional operands |
| sat_i | input | 1 | Clamp out-of-range results |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| acc_wr_i | input | 1 | Direct accumulator load strobe |
| acc_wdata_i | input | 32 | Value for the direct load |
| acc_o | output | 32 | Accumulator value |
| ovf_o | output | 1 | Sticky overflow flag |
| zero_o | output | 1 | Accumulator is zero |
| neg_o | output | 1 | Accumulator sign bit |

## Verification
The hardest situation to reach from the ports is a direct accumulator load landing on the same edge as a completing accumulate. The stimulus issues an operation and asserts `acc_wr_i` exactly two cycles later. It then checks that the loaded value survives one more edge untouched.

Overflow on a plain load is also rare. It occurs only for the fractional product of 0x8000 with itself. The sweep reaches it because it crosses the boundary operands 0x8000, 0x7FFF and 0xFFFF with preloaded accumulators near each range limit, in every mode, opcode and saturation setting.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_NOP  = 2'b11
  } mac_op_e;

  typedef struct packed {
    logic    valid;
    mac_op_e op;
    logic    sgn;
    logic    frac;
    logic    sat;
  } mac_ctl_t;
endpackage

// File: rtl/mac_operand_stage.sv
module mac_operand_stage
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  localparam int EXTW = OPW + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [1:0]             op_i,
  input  logic                   signed_i,
  input  logic                   frac_i,
  input  logic                   sat_i,
  input  logic [OPW-1:0]         a_i,
  input  logic [OPW-1:0]         b_i,
  output mac_ctl_t               ctl_o,
  output logic signed [EXTW-1:0] a_o,
  output logic signed [EXTW-1:0] b_o
);
  logic sgn;
  assign sgn = signed_i | frac_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
      a_o   <= '0;
      b_o   <= '0;
    end else begin
      ctl_o.valid <= valid_i;
      ctl_o.op    <= mac_op_e'(op_i);
      ctl_o.sgn   <= sgn;
      ctl_o.frac  <= frac_i;
      ctl_o.sat   <= sat_i;
      // extra top bit: sign copy or zero, so one signed multiplier serves all modes
      a_o <= {sgn & a_i[OPW-1], a_i};
      b_o <= {sgn & b_i[OPW-1], b_i};
    end
  end
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int OPW   = 16,
  localparam int EXTW  = OPW + 1,
  localparam int PRODW = 2 * EXTW + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  mac_ctl_t                ctl_i,
  input  logic signed [EXTW-1:0]  a_i,
  input  logic signed [EXTW-1:0]  b_i,
  output mac_ctl_t                ctl_o,
  output logic signed [PRODW-1:0] prod_o
);
  logic signed [2*EXTW-1:0] mul;
  logic signed [PRODW-1:0]  mul_ext;
  logic signed [PRODW-1:0]  prod_n;

  assign mul     = a_i * b_i;
  assign mul_ext = {mul[2*EXTW-1], mul};
  assign prod_n  = ctl_i.frac ? (mul_ext <<< 1) : mul_ext;  // Q15*Q15 -> Q31

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      prod_o <= '0;
    end else begin
      ctl_o  <= ctl_i;
      prod_o <= prod_n;
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int ACCW  = 32,
  localparam int PRODW = 2 * (OPW + 1) + 1,
  localparam int SUMW  = ((ACCW + 1 > PRODW) ? ACCW + 1 : PRODW) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  mac_ctl_t                ctl_i,
  input  logic signed [PRODW-1:0] prod_i,
  input  logic                    acc_wr_i,
  input  logic [ACCW-1:0]         acc_wdata_i,
  output logic [ACCW-1:0]         acc_o,
  output logic                    ovf_o
);
  localparam logic signed [SUMW-1:0] S_MAX = {{(SUMW-ACCW+1){1'b0}}, {(ACCW-1){1'b1}}};
  localparam logic signed [SUMW-1:0] S_MIN = {{(SUMW-ACCW+1){1'b1}}, {(ACCW-1){1'b0}}};
  localparam logic signed [SUMW-1:0] U_MAX = {{(SUMW-ACCW){1'b0}}, {ACCW{1'b1}}};
  localparam logic [ACCW-1:0] A_SMAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] A_SMIN = {1'b1, {(ACCW-1){1'b0}}};

  logic [ACCW-1:0]        acc_q;
  logic                   ovf_q;
  logic signed [SUMW-1:0] acc_ext, prod_ext, sum;
  logic                   hi_ovf, lo_ovf, upd;
  logic [ACCW-1:0]        res;

  assign acc_ext  = ctl_i.sgn ? {{(SUMW-ACCW){acc_q[ACCW-1]}}, acc_q}
                              : {{(SUMW-ACCW){1'b0}}, acc_q};
  assign prod_ext = {{(SUMW-PRODW){prod_i[PRODW-1]}}, prod_i};
  assign upd      = ctl_i.valid && (ctl_i.op != OP_NOP);

  always_comb begin
    unique case (ctl_i.op)
      OP_LOAD: sum = prod_ext;
      OP_ADD:  sum = acc_ext + prod_ext;
      OP_SUB:  sum = acc_ext - prod_ext;
      default: sum = acc_ext;
    endcase
  end

  assign hi_ovf = ctl_i.sgn ? (sum > S_MAX) : (sum > U_MAX);
  assign lo_ovf = ctl_i.sgn ? (sum < S_MIN) : (sum < 0);

  always_comb begin
    res = sum[ACCW-1:0];
    if (ctl_i.sat && hi_ovf) res = ctl_i.sgn ? A_SMAX : '1;
    if (ctl_i.sat && lo_ovf) res = ctl_i.sgn ? A_SMIN : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_wr_i) begin
      acc_q <= acc_wdata_i;
      ovf_q <= 1'b0;
    end else if (upd) begin
      acc_q <= res;
      ovf_q <= ovf_q | hi_ovf | lo_ovf;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.valid && !acc_wr_i) |=> $stable(acc_q));

  assert_nop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.valid && ctl_i.op == OP_NOP && !acc_wr_i) |=> ($stable(acc_q) && $stable(ovf_q)));

  assert_sat_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !acc_wr_i && ctl_i.sat && (hi_ovf || lo_ovf))
      |=> (ovf_q && (acc_q == A_SMAX || acc_q == A_SMIN || acc_q == '1 || acc_q == '0)));

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !acc_wr_i) |=> ovf_q);

  assert_wr_priority_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr_i |=> (acc_q == $past(acc_wdata_i) && !ovf_q));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int ACCW  = 32,
  localparam int EXTW  = OPW + 1,
  localparam int PRODW = 2 * EXTW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic            signed_i,
  input  logic            frac_i,
  input  logic            sat_i,
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  input  logic            acc_wr_i,
  input  logic [ACCW-1:0] acc_wdata_i,
  output logic [ACCW-1:0] acc_o,
  output logic            ovf_o,
  output logic            zero_o,
  output logic            neg_o
);
  mac_ctl_t                s1_ctl, s2_ctl;
  logic signed [EXTW-1:0]  s1_a, s1_b;
  logic signed [PRODW-1:0] s2_prod;

  mac_operand_stage #(.OPW(OPW)) u_opnd (
    .clk_i, .rst_ni, .valid_i, .op_i, .signed_i, .frac_i, .sat_i, .a_i, .b_i,
    .ctl_o(s1_ctl), .a_o(s1_a), .b_o(s1_b)
  );

  mac_mult_stage #(.OPW(OPW)) u_mult (
    .clk_i, .rst_ni, .ctl_i(s1_ctl), .a_i(s1_a), .b_i(s1_b),
    .ctl_o(s2_ctl), .prod_o(s2_prod)
  );

  mac_acc_stage #(.OPW(OPW), .ACCW(ACCW)) u_acc (
    .clk_i, .rst_ni, .ctl_i(s2_ctl), .prod_i(s2_prod),
    .acc_wr_i, .acc_wdata_i, .acc_o, .ovf_o
  );

  assign zero_o = (acc_o == '0);
  assign neg_o  = acc_o[ACCW-1];

  assert_pipe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_ctl.valid ##1 s2_ctl.valid);

  assert_no_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && s1_ctl.valid) |=> (s1_ctl.valid && s2_ctl.valid));
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        sgn = 1'b0, frac = 1'b0, sat = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc;
  logic        ovf, zero, neg;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_acc = '0;
  bit          exp_ovf = 1'b0;

  always #4 clk = ~clk;

  mac_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .signed_i(sgn),
    .frac_i(frac), .sat_i(sat), .a_i(a), .b_i(b), .acc_wr_i(acc_wr),
    .acc_wdata_i(acc_wdata), .acc_o(acc), .ovf_o(ovf), .zero_o(zero), .neg_o(neg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " acc"}, acc, exp_acc);
    check({req, " ovf R10"}, 32'(ovf), 32'(exp_ovf));
    check({req, " zero R12"}, 32'(zero), 32'(exp_acc == 0));
    check({req, " neg R12"}, 32'(neg), 32'(exp_acc[31]));
  endtask

  function automatic void model_step(input int o, input bit sg, input bit fr, input bit st,
                                     input logic [15:0] x, input logic [15:0] y);
    longint px, py, p, base, r, hi, lo;
    bit s;
    s  = sg | fr;
    px = s ? longint'($signed(x)) : longint'(x);
    py = s ? longint'($signed(y)) : longint'(y);
    p  = px * py;
    if (fr) p = p * 2;
    base = s ? longint'($signed(exp_acc)) : longint'(exp_acc);
    hi = s ? (longint'(1) <<< 31) - 1 : (longint'(1) <<< 32) - 1;
    lo = s ? -(longint'(1) <<< 31) : 0;
    if (o == 0) r = p;
    else if (o == 1) r = base + p;
    else if (o == 2) r = base - p;
    else return;
    if (r > hi) begin
      exp_ovf = 1'b1;
      r = st ? hi : r;
    end else if (r < lo) begin
      exp_ovf = 1'b1;
      r = st ? lo : r;
    end
    exp_acc = r[31:0];
  endfunction

  task automatic write_acc(input logic [31:0] v);
    @(negedge clk);
    acc_wr = 1'b1; acc_wdata = v;
    @(negedge clk);
    acc_wr = 1'b0;
    exp_acc = v; exp_ovf = 1'b0;
  endtask

  task automatic drive_op(input int o, input bit sg, input bit fr, input bit st,
                          input logic [15:0] x, input logic [15:0] y);
    valid = 1'b1; op = 2'(o); sgn = sg; frac = fr; sat = st; a = x; b = y;
  endtask

  task automatic issue(input int o, input bit sg, input bit fr, input bit st,
                       input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    drive_op(o, sg, fr, st, x, y);
    @(negedge clk);
    valid = 1'b0;
    model_step(o, sg, fr, st, x, y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    logic [31:0] accs [5];
    string tag;
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
    accs = '{32'h0000_0000, 32'h7FFF_FFF0, 32'h8000_0010, 32'hFFFF_FFF0, 32'h0001_2345};

    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;

    // R2 latency: signed 3*5 load
    write_acc(32'hDEAD_0000);
    @(negedge clk);
    drive_op(0, 1, 0, 0, 16'd3, 16'd5);
    @(negedge clk);
    valid = 1'b0;
    check("R2 after edge 1", acc, 32'hDEAD_0000);
    @(negedge clk);
    check("R2 after edge 2", acc, 32'hDEAD_0000);
    @(negedge clk);
    check("R2 after edge 3", acc, 32'd15);
    exp_acc = 32'd15;

    // sweep: R3/R4/R5 modes, R6 ops, R8/R9 saturation
    for (int m = 0; m < 3; m++)
      for (int o = 0; o < 3; o++)
        for (int st = 0; st < 2; st++)
          for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
              write_acc(accs[(i + j + o) % 5]);
              issue(o, m == 1, m == 2, st[0], vals[i], vals[j]);
              repeat (2) @(negedge clk);
              tag = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
              tag = {tag, " R6 ", (st != 0) ? "R8" : "R9"};
              check_all(tag);
            end

    // R6: opcode 11 leaves acc and ovf unchanged
    write_acc(32'h7FFF_FFFF);
    issue(1, 1, 0, 0, 16'd1, 16'd1);  // wraps, sets ovf
    repeat (2) @(negedge clk);
    check_all("R9 wrap");
    issue(3, 1, 0, 1, 16'h1234, 16'h0002);
    repeat (2) @(negedge clk);
    check_all("R6 nop");

    // R10: ovf stays set through a later in-range op
    issue(0, 1, 0, 0, 16'd1, 16'd1);
    repeat (2) @(negedge clk);
    check_all("R10 sticky");
    write_acc(32'h0000_0007);
    check_all("R10 cleared by write R11");

    // R7: back-to-back issue every cycle
    write_acc(32'd100);
    @(negedge clk);
    drive_op(1, 1, 0, 0, 16'd2, 16'd3);     model_step(1, 1, 0, 0, 16'd2, 16'd3);
    @(negedge clk);
    drive_op(2, 1, 0, 0, 16'd4, 16'hFFFF);  model_step(2, 1, 0, 0, 16'd4, 16'hFFFF);
    @(negedge clk);
    drive_op(1, 0, 0, 0, 16'hFFFF, 16'd2);  model_step(1, 0, 0, 0, 16'hFFFF, 16'd2);
    @(negedge clk);
    drive_op(1, 0, 1, 1, 16'h4000, 16'h4000); model_step(1, 0, 1, 1, 16'h4000, 16'h4000);
    @(negedge clk);
    valid = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7 back-to-back");

    // R11: write collides with completing accumulate
    write_acc(32'd50);
    @(negedge clk);
    drive_op(1, 1, 0, 0, 16'd10, 16'd10);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    acc_wr = 1'b1; acc_wdata = 32'hCAFE_0001;
    @(negedge clk);
    acc_wr = 1'b0;
    exp_acc = 32'hCAFE_0001; exp_ovf = 1'b0;
    check_all("R11 priority");
    @(negedge clk);
    check_all("R11 op discarded");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule